// File: doc/BRIEF.md
# Binary64 to 32-bit Integer Converter

This unit takes one IEEE 754 binary64 operand per beat and turns it into a 32-bit integer, either signed or unsigned. It follows the usual scalar-core conversion rules. The rounding mode arrives with the operand. An operand that was not validly boxed in its register is treated as a NaN. The datapath first works out the magnitude with guard and sticky bits, then applies the rounding mode. It then builds two candidates: a rounded integer and a saturated code. A final multiplexer picks one of them after checking the range of the *rounded* value. Because of this, an operand of exactly -2^31 (`0xC1E0000000000000`) is an ordinary in-range value and gives `0x80000000` with no flags. The operands +2^31 and -2^31-1 are out of range.

The operand enters through a valid/ready stream, and the result leaves through one; there is a single register stage between them. An input beat is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled output back-pressures the input directly. While `out_valid` is high and `out_ready` is low, the result and both flags hold their values.

Top module: `f2i_cvt_unit`

## Requirements
- R1: A beat accepted at a clock edge appears at the output after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_invalid` and `out_inexact` stay unchanged, and no new beat is taken.
- R2: In signed mode (`in_unsigned`=0), every finite value whose rounded result lies in [-2^31, 2^31-1] gives that integer in two's complement. Exactly -2^31 gives `0x80000000` with `out_invalid`=0 and never `0x00000000`. A value that rounds to -2^31 is also in range.
- R3: In signed mode, a value that rounds above 2^31-1 gives `0x7FFFFFFF`, and one that rounds below -2^31 gives `0x80000000`; both set `out_invalid`. This covers +2^31, -2^31-1, and any magnitude of 2^33 or more.
- R4: A NaN of either sign, or any operand with `in_boxed`=0, gives `0x7FFFFFFF` in signed mode and `0xFFFFFFFF` in unsigned mode, with `out_invalid`=1.
- R5: +infinity gives `0x7FFFFFFF` (signed) or `0xFFFFFFFF` (unsigned). -infinity gives `0x80000000` (signed) or `0x00000000` (unsigned). Both set `out_invalid`.
- R6: In unsigned mode (`in_unsigned`=1), rounded values in [0, 2^32-1] are returned unchanged. A value that rounds above that gives `0xFFFFFFFF`, and a negative value that rounds to a nonzero integer gives `0x00000000`; both set `out_invalid`. A negative value that rounds to zero gives 0 without `out_invalid`.
- R7: `in_rm` selects the rounding: 3'b000 nearest with ties to even, 3'b001 toward zero, 3'b010 toward minus infinity, 3'b011 toward plus infinity, 3'b100 nearest with ties away from zero.
- R8: The codes 3'b101, 3'b110 and 3'b111 of `in_rm` round like 3'b000.
- R9: Both zeros give 0 with no flags. A nonzero subnormal gives 0, or 1 or -1 when a directed rounding moves it away from zero, and sets `out_inexact`.
- R10: `out_invalid` and `out_inexact` are never both set. `out_inexact` is set exactly when the result is not saturated and the operand is not an integer.
- R11: While `rst_n` is low, and right after it rises, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take the input beat |
| in_operand | input | EXP_W+MAN_W+1 (64) | Binary64 source operand |
| in_boxed | input | 1 | 1 when the operand is validly boxed; 0 forces NaN treatment |
| in_rm | input | 3 | Rounding mode code |
| in_unsigned | input | 1 | 1 selects an unsigned destination, 0 signed |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| out_result | output | INT_W (32) | Converted or saturated integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bench builds the unit with its default parameters: an 11-bit exponent, a 52-bit fraction and a 32-bit integer destination. With these, the exact binary64 encodings of ±2^31, -2^31-1, 2^32-1 and 2^32 can be written as literal vectors. So can the half-integer operands 2^31-0.5 and -2^31-0.5, whose in-range or out-of-range verdict changes with the rounding mode. That makes it possible to check that the range test is applied after rounding. Small ties such as ±0.5, 1.5 and ±2.5, together with the smallest subnormals, exercise every rounding code including the reserved ones. A stalled output is held for several cycles to confirm that back-pressure freezes the result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [2:0] {
    RM_RNE = 3'b000,
    RM_RTZ = 3'b001,
    RM_RDN = 3'b010,
    RM_RUP = 3'b011,
    RM_RMM = 3'b100
  } rnd_mode_e;

  // Classification and rounding bits of a decoded operand
  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_inf;
    logic of_pre;   // magnitude already too big before rounding
    logic guard;
    logic sticky;
  } fp_info_t;

endpackage

// File: rtl/f2i_decode.sv
module f2i_decode
  import f2i_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] op,
  output fp_info_t             info,
  output logic [INT_W:0]       mag
);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W = MAN_W + 1;
  localparam int SH_W  = $clog2(INT_W + 1);

  logic [EXP_W-1:0]       exp_f;
  logic [MAN_W-1:0]       man_f;
  logic                   exp_max, exp_zero, man_nz;
  int                     ue;
  logic [SH_W-1:0]        sh;
  logic [INT_W+SIG_W-1:0] xs;

  assign exp_f    = op[MAN_W +: EXP_W];
  assign man_f    = op[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_nz   = |man_f;

  always_comb begin
    info      = '0;
    info.sign = op[EXP_W+MAN_W];
    mag       = '0;
    sh        = '0;
    xs        = '0;
    ue        = int'(exp_f) - BIAS;
    if (exp_max) begin
      info.is_nan = man_nz;
      info.is_inf = ~man_nz;
    end else if (exp_zero) begin
      info.sticky = man_nz;            // subnormal: below one half
    end else if (ue > INT_W) begin
      info.of_pre = 1'b1;
    end else if (ue < -1) begin
      info.sticky = 1'b1;
    end else if (ue == -1) begin
      info.guard  = 1'b1;
      info.sticky = man_nz;
    end else begin
      // left-align the significand so the integer part sits above MAN_W
      sh          = SH_W'(ue);
      xs          = {{INT_W{1'b0}}, 1'b1, man_f} << sh;
      mag         = xs[MAN_W +: INT_W+1];
      info.guard  = xs[MAN_W-1];
      info.sticky = |xs[MAN_W-2:0];
    end
  end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W:0]   mag,
  input  logic             sign,
  input  logic             guard,
  input  logic             sticky,
  input  logic [2:0]       rm,
  output logic [INT_W+1:0] mag_r
);
  logic up;

  always_comb begin
    case (rnd_mode_e'(rm))
      RM_RTZ:  up = 1'b0;
      RM_RDN:  up = sign & (guard | sticky);
      RM_RUP:  up = ~sign & (guard | sticky);
      RM_RMM:  up = guard;
      default: up = guard & (sticky | mag[0]);  // ties to even, also reserved codes
    endcase
    mag_r = {1'b0, mag} + {{(INT_W+1){1'b0}}, up};
  end

endmodule

// File: rtl/f2i_select.sv
module f2i_select
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  fp_info_t         info,
  input  logic [INT_W+1:0] mag_r,
  input  logic             boxed,
  input  logic             is_uns,
  output logic [INT_W-1:0] res,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [INT_W+1:0] LIM_POS_S = {3'b000, {(INT_W-1){1'b1}}};
  localparam logic [INT_W+1:0] LIM_NEG_S = {2'b00, 1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W+1:0] LIM_U     = {2'b00, {INT_W{1'b1}}};
  localparam logic [INT_W-1:0] SAT_MAX_S = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_MIN_S = {1'b1, {(INT_W-1){1'b0}}};

  logic             nan_like, range_bad, special;
  logic [INT_W-1:0] sat, mag_t, rounded;

  always_comb begin
    nan_like = info.is_nan | ~boxed;
    // range is judged on the rounded magnitude, so -2^31 stays legal
    if (is_uns) range_bad = info.sign ? (mag_r != '0) : (mag_r > LIM_U);
    else        range_bad = info.sign ? (mag_r > LIM_NEG_S) : (mag_r > LIM_POS_S);
    special = nan_like | info.is_inf | info.of_pre | range_bad;

    if (is_uns) sat = (nan_like | ~info.sign) ? '1 : '0;
    else        sat = (nan_like | ~info.sign) ? SAT_MAX_S : SAT_MIN_S;

    mag_t   = mag_r[INT_W-1:0];
    rounded = (info.sign & ~is_uns) ? (~mag_t + INT_W'(1)) : mag_t;

    res     = special ? sat : rounded;
    invalid = special;
    inexact = ~special & (info.guard | info.sticky);
  end

endmodule

// File: rtl/f2i_cvt_unit.sv
module f2i_cvt_unit
  import f2i_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+MAN_W:0]   in_operand,
  input  logic                   in_boxed,
  input  logic [2:0]             in_rm,
  input  logic                   in_unsigned,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [INT_W-1:0]       out_result,
  output logic                   out_invalid,
  output logic                   out_inexact
);
  localparam logic [INT_W-1:0] SAT_MAX_S = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] SAT_MIN_S = {1'b1, {(INT_W-1){1'b0}}};

  fp_info_t         info;
  logic [INT_W:0]   mag;
  logic [INT_W+1:0] mag_r;
  logic [INT_W-1:0] c_res;
  logic             c_inv, c_inx;

  f2i_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_dec (
    .op(in_operand), .info(info), .mag(mag)
  );

  f2i_round #(.INT_W(INT_W)) u_rnd (
    .mag(mag), .sign(info.sign), .guard(info.guard), .sticky(info.sticky),
    .rm(in_rm), .mag_r(mag_r)
  );

  f2i_select #(.INT_W(INT_W)) u_sel (
    .info(info), .mag_r(mag_r), .boxed(in_boxed), .is_uns(in_unsigned),
    .res(c_res), .invalid(c_inv), .inexact(c_inx)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) begin
        out_result  <= c_res;
        out_invalid <= c_inv;
        out_inexact <= c_inx;
      end
    end
  end

  // R1
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_invalid) && $stable(out_inexact));

  // R1
  accept_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  // R3
  sat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> (out_result == SAT_MAX_S) || (out_result == SAT_MIN_S) ||
                                 (out_result == '1) || (out_result == '0));

  // R11
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/sim_f2i_cvt_unit.sv
module sim_f2i_cvt_unit;
  // vector: operand, boxed, rm, unsigned, result, invalid, inexact, req
  localparam int NV = 60;
  localparam logic [106:0] VECS [0:NV-1] = '{
    {64'hC1E0000000000000, 1'b1, 3'd0, 1'b0, 32'h80000000, 1'b0, 1'b0, 4'd2},
    {64'h41DFFFFFFFC00000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b0, 4'd2},
    {64'hC1E0000000100000, 1'b1, 3'd0, 1'b0, 32'h80000000, 1'b0, 1'b1, 4'd2},
    {64'hC1E0000000100000, 1'b1, 3'd1, 1'b0, 32'h80000000, 1'b0, 1'b1, 4'd2},
    {64'h3FF0000000000000, 1'b1, 3'd0, 1'b0, 32'h00000001, 1'b0, 1'b0, 4'd2},
    {64'h41E0000000000000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3},
    {64'hC1E0000000200000, 1'b1, 3'd0, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd3},
    {64'hC1E0000000100000, 1'b1, 3'd2, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd3},
    {64'h41DFFFFFFFE00000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3},
    {64'h7FE0000000000000, 1'b1, 3'd1, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd3},
    {64'hFFE0000000000000, 1'b1, 3'd1, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd3},
    {64'h7FF8000000000000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd4},
    {64'hFFF8000000000000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd4},
    {64'h7FF8000000000000, 1'b1, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd4},
    {64'h3FF0000000000000, 1'b0, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd4},
    {64'h3FF0000000000000, 1'b0, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd4},
    {64'h7FF0000000000000, 1'b1, 3'd0, 1'b0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'd5},
    {64'hFFF0000000000000, 1'b1, 3'd0, 1'b0, 32'h80000000, 1'b1, 1'b0, 4'd5},
    {64'h7FF0000000000000, 1'b1, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd5},
    {64'hFFF0000000000000, 1'b1, 3'd0, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd5},
    {64'h41EFFFFFFFE00000, 1'b1, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 4'd6},
    {64'h41F0000000000000, 1'b1, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 4'd6},
    {64'h41E0000000000000, 1'b1, 3'd0, 1'b1, 32'h80000000, 1'b0, 1'b0, 4'd6},
    {64'hC1E0000000000000, 1'b1, 3'd0, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd6},
    {64'hBFE0000000000000, 1'b1, 3'd1, 1'b1, 32'h00000000, 1'b0, 1'b1, 4'd6},
    {64'hBFE0000000000000, 1'b1, 3'd2, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd6},
    {64'hBFF8000000000000, 1'b1, 3'd0, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd6},
    {64'h4004000000000000, 1'b1, 3'd3, 1'b1, 32'h00000003, 1'b0, 1'b1, 4'd6},
    {64'h4004000000000000, 1'b1, 3'd0, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'h4004000000000000, 1'b1, 3'd1, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'h4004000000000000, 1'b1, 3'd2, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'h4004000000000000, 1'b1, 3'd3, 1'b0, 32'h00000003, 1'b0, 1'b1, 4'd7},
    {64'h4004000000000000, 1'b1, 3'd4, 1'b0, 32'h00000003, 1'b0, 1'b1, 4'd7},
    {64'hC004000000000000, 1'b1, 3'd0, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd7},
    {64'hC004000000000000, 1'b1, 3'd1, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd7},
    {64'hC004000000000000, 1'b1, 3'd2, 1'b0, 32'hFFFFFFFD, 1'b0, 1'b1, 4'd7},
    {64'hC004000000000000, 1'b1, 3'd3, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd7},
    {64'hC004000000000000, 1'b1, 3'd4, 1'b0, 32'hFFFFFFFD, 1'b0, 1'b1, 4'd7},
    {64'h3FF8000000000000, 1'b1, 3'd0, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'h3FF8000000000000, 1'b1, 3'd1, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd7},
    {64'h3FF8000000000000, 1'b1, 3'd2, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd7},
    {64'h3FF8000000000000, 1'b1, 3'd3, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'h3FF8000000000000, 1'b1, 3'd4, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd7},
    {64'hBFE0000000000000, 1'b1, 3'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd7},
    {64'hBFE0000000000000, 1'b1, 3'd2, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd7},
    {64'hBFE0000000000000, 1'b1, 3'd3, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd7},
    {64'hBFE0000000000000, 1'b1, 3'd4, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd7},
    {64'h3FE0000000000000, 1'b1, 3'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd7},
    {64'h3FE0000000000000, 1'b1, 3'd4, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd7},
    {64'h4004000000000000, 1'b1, 3'd5, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd8},
    {64'h3FF8000000000000, 1'b1, 3'd7, 1'b0, 32'h00000002, 1'b0, 1'b1, 4'd8},
    {64'hC004000000000000, 1'b1, 3'd6, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b1, 4'd8},
    {64'h0000000000000000, 1'b1, 3'd0, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd9},
    {64'h8000000000000000, 1'b1, 3'd2, 1'b0, 32'h00000000, 1'b0, 1'b0, 4'd9},
    {64'h0000000000000001, 1'b1, 3'd0, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd9},
    {64'h0000000000000001, 1'b1, 3'd3, 1'b0, 32'h00000001, 1'b0, 1'b1, 4'd9},
    {64'h8000000000000001, 1'b1, 3'd2, 1'b0, 32'hFFFFFFFF, 1'b0, 1'b1, 4'd9},
    {64'h8000000000000001, 1'b1, 3'd3, 1'b0, 32'h00000000, 1'b0, 1'b1, 4'd9},
    {64'h8000000000000001, 1'b1, 3'd2, 1'b1, 32'h00000000, 1'b1, 1'b0, 4'd9},
    {64'h41DFFFFFFFE00000, 1'b1, 3'd1, 1'b0, 32'h7FFFFFFF, 1'b0, 1'b1, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic        in_boxed = 1'b1;
  logic [2:0]  in_rm = '0;
  logic        in_unsigned = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid, out_inexact;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  f2i_cvt_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_boxed(in_boxed), .in_rm(in_rm),
    .in_unsigned(in_unsigned), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [106:0] v);
    in_valid    = 1'b1;
    in_operand  = v[106:43];
    in_boxed    = v[42];
    in_rm       = v[41:39];
    in_unsigned = v[38];
  endtask

  task automatic run_vec(input int idx);
    logic [106:0] v;
    v = VECS[idx];
    @(negedge clk);
    drive(v);
    @(negedge clk);
    in_valid = 1'b0;
    check(req_name(v[3:0]), $sformatf("vec %0d {result,inv,inx}", idx),
          {30'd0, out_valid, out_result, out_invalid, out_inexact},
          {30'd0, 1'b1, v[37:6], v[5], v[4]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11: state while reset is held and just after release
    repeat (3) @(negedge clk);
    check("R11", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R11", "in_ready in reset", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "out_valid after reset", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: back-pressure holds the result and blocks the input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]);                         // -2^31 signed
    @(negedge clk);
    drive({64'h3FF0000000000000, 1'b1, 3'd0, 1'b0, 32'd1, 1'b0, 1'b0, 4'd2});
    check("R1", "stalled accept", {30'd0, out_valid, out_result, out_invalid, out_inexact},
          {30'd0, 1'b1, 32'h80000000, 1'b0, 1'b0});
    check("R1", "in_ready while stalled", {63'd0, in_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check("R1", "held result", {30'd0, out_valid, out_result, out_invalid, out_inexact},
          {30'd0, 1'b1, 32'h80000000, 1'b0, 1'b0});
    out_ready = 1'b1;                       // edge drains old, takes 1.0
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "next beat after drain", {30'd0, out_valid, out_result, out_invalid, out_inexact},
          {30'd0, 1'b1, 32'h00000001, 1'b0, 1'b0});
    @(negedge clk);
    check("R1", "empty after drain", {63'd0, out_valid}, 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule